// File: doc/BRIEF.md
# Header-Addressed Crossbar Packet Switch

A small packet switch with a parameterised number of ports. Every port has an ingress side and an egress side. Each side carries one character per transfer: an 8-bit value and a flag that marks the character as data or control. A transfer takes place on a clock edge where valid and ready are both high. The first data character of a packet is the route. The switch reads it, drops it, and connects the ingress to the egress port that it names. Every character after the header then flows straight through the crossbar until a control character (an end marker) has passed. That marker is delivered to the egress and frees the path.

An ingress that is waiting for a busy egress keeps its header and takes nothing more until it gets a grant. A waiting ingress holds no egress, so waits cannot form a cycle. Two ingresses that want the same free egress in the same cycle are served in round-robin order. Back-pressure from an egress's receiver reaches the ingress that is connected to it, and no character is lost. A header that names no existing port makes the switch discard the whole packet.

Top module: `pkt_xbar_router`

## Requirements
- R1: After reset every `out_valid_o` bit is 0 and every `in_ready_o` bit is 1.
- R2: A data character (ctrl flag 0) that arrives at an idle ingress is a header. If its value v is below NUM_PORTS, it routes the packet to egress v. The header never appears at an egress, and the next character is the first one the egress delivers.
- R3: Payload characters reach the selected egress unchanged, with their ctrl flag and in their original order.
- R4: A control character ends the packet. Its data bit 0 is 0 for end-of-packet and 1 for end-of-message. It is delivered as the last character of the packet. The egress can be granted again from the following cycle, and both marker codes behave the same way.
- R5: Each egress has its own round-robin pointer, which starts at NUM_PORTS-1. When several ingresses request a free egress in the same cycle, the grant goes to the first requester above the last granted index, wrapping around.
- R6: An ingress that loses arbitration holds `in_ready_o` low and keeps its header. Once the egress is released it is granted without resending the header, and its packet is never interleaved with another.
- R7: While a connected egress has `out_ready_i` low, the connected ingress sees `in_ready_o` low, and `out_valid_o` and `out_data_o` hold their values. No character is lost or duplicated.
- R8: A header with value at least NUM_PORTS causes the packet to be accepted and discarded up to and including its end marker. No egress asserts valid.
- R9: Connections with disjoint ingress and egress ports transfer at the same time and do not disturb each other.
- R10: Each egress is connected to at most one ingress at any time.
- R11: A control character that arrives at an idle ingress is consumed and has no effect at any egress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | NUM_PORTS | Ingress character valid, one bit per port |
| in_ctrl_i | input | NUM_PORTS | Ingress control flag, 1 = control character |
| in_data_i | input | NUM_PORTS*CHAR_W | Ingress character values, port p at bits [p*CHAR_W +: CHAR_W] |
| in_ready_o | output | NUM_PORTS | Ingress may transfer (flow control toward the sender) |
| out_valid_o | output | NUM_PORTS | Egress character valid |
| out_ctrl_o | output | NUM_PORTS | Egress control flag |
| out_data_o | output | NUM_PORTS*CHAR_W | Egress character values, same packing as ingress |
| out_ready_i | input | NUM_PORTS | Downstream receiver holds credit for one character |

## Verification
Arbitration for one egress can coincide in a cycle with the release of a different egress, and it can coincide with other connections that are forwarding data. The bench provokes both. It starts two packets aimed at the same egress on the same clock edge, and it runs other disjoint packets in parallel. The result is judged from the character sequence captured at each egress. The sequence must show the round-robin winner's packet complete before the loser's, with no header leaking through and no interleaving.

// File: rtl/pkt_xbar_pkg.sv
package pkt_xbar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,  // expecting header
    ST_REQ  = 2'd1,  // header held, requesting egress
    ST_FWD  = 2'd2,  // connected
    ST_DROP = 2'd3   // discarding misrouted packet
  } ing_state_e;
endpackage

// File: rtl/pkt_xbar_ingress.sv
module pkt_xbar_ingress
  import pkt_xbar_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int CHAR_W    = 8,
  parameter int AW        = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              ctrl_i,
  input  logic [CHAR_W-1:0] data_i,
  input  logic              fwd_ready_i,
  input  logic              grant_i,
  output logic              ready_o,
  output logic              req_o,
  output logic [AW-1:0]     dest_o,
  output logic [1:0]        state_o,
  output logic              release_o
);
  ing_state_e st_q, st_d;
  logic [AW-1:0] dest_q;
  logic hdr_ok;

  assign hdr_ok    = data_i < CHAR_W'(NUM_PORTS);
  assign req_o     = (st_q == ST_REQ);
  assign dest_o    = dest_q;
  assign state_o   = st_q;
  assign release_o = (st_q == ST_FWD) && valid_i && ctrl_i && fwd_ready_i;

  always_comb begin
    unique case (st_q)
      ST_IDLE: ready_o = 1'b1;
      ST_REQ:  ready_o = 1'b0;
      ST_FWD:  ready_o = fwd_ready_i;
      default: ready_o = 1'b1;
    endcase
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (valid_i && !ctrl_i) st_d = hdr_ok ? ST_REQ : ST_DROP;
      ST_REQ:  if (grant_i) st_d = ST_FWD;
      ST_FWD:  if (release_o) st_d = ST_IDLE;
      default: if (valid_i && ctrl_i) st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      dest_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && valid_i && !ctrl_i) dest_q <= data_i[AW-1:0];
    end
  end
endmodule

// File: rtl/pkt_xbar_arb.sv
module pkt_xbar_arb #(
  parameter int NUM_PORTS = 4,
  parameter int AW        = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PORTS-1:0] req_i,
  input  logic [NUM_PORTS-1:0] rel_i,
  output logic                 busy_o,
  output logic [AW-1:0]        owner_o,
  output logic [NUM_PORTS-1:0] gnt_o
);
  logic          busy_q;
  logic [AW-1:0] owner_q, ptr_q, pick;
  logic          pick_ok;
  logic [AW:0]   idx;

  always_comb begin
    pick_ok = 1'b0;
    pick    = ptr_q;
    idx     = '0;
    for (int k = 1; k <= NUM_PORTS; k++) begin
      idx = {1'b0, ptr_q} + (AW+1)'(k);
      if (idx >= (AW+1)'(NUM_PORTS)) idx = idx - (AW+1)'(NUM_PORTS);
      if (!busy_q && !pick_ok && req_i[idx[AW-1:0]]) begin
        pick_ok = 1'b1;
        pick    = idx[AW-1:0];
      end
    end
    gnt_o = '0;
    if (pick_ok) gnt_o[pick] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      owner_q <= '0;
      ptr_q   <= AW'(NUM_PORTS-1);
    end else if (pick_ok) begin
      busy_q  <= 1'b1;
      owner_q <= pick;
      ptr_q   <= pick;
    end else if (busy_q && rel_i[owner_q]) begin
      busy_q <= 1'b0;
    end
  end

  assign busy_o  = busy_q;
  assign owner_o = owner_q;
endmodule

// File: rtl/pkt_xbar_fabric.sv
module pkt_xbar_fabric #(
  parameter int NUM_PORTS = 4,
  parameter int CHAR_W    = 8,
  parameter int AW        = 2
) (
  input  logic [NUM_PORTS-1:0]        in_valid_i,
  input  logic [NUM_PORTS-1:0]        in_ctrl_i,
  input  logic [NUM_PORTS*CHAR_W-1:0] in_data_i,
  input  logic [NUM_PORTS*AW-1:0]     dest_i,
  input  logic [NUM_PORTS-1:0]        busy_i,
  input  logic [NUM_PORTS*AW-1:0]     owner_i,
  input  logic [NUM_PORTS-1:0]        out_ready_i,
  output logic [NUM_PORTS-1:0]        out_valid_o,
  output logic [NUM_PORTS-1:0]        out_ctrl_o,
  output logic [NUM_PORTS*CHAR_W-1:0] out_data_o,
  output logic [NUM_PORTS-1:0]        fwd_ready_o
);
  for (genvar j = 0; j < NUM_PORTS; j++) begin : g_egress
    logic [AW-1:0] own;
    assign own = owner_i[j*AW +: AW];
    assign out_valid_o[j]                 = busy_i[j] && in_valid_i[own];
    assign out_ctrl_o[j]                  = busy_i[j] && in_ctrl_i[own];
    assign out_data_o[j*CHAR_W +: CHAR_W] = busy_i[j] ? in_data_i[own*CHAR_W +: CHAR_W] : '0;
  end

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_ingress
    assign fwd_ready_o[i] = out_ready_i[dest_i[i*AW +: AW]];
  end
endmodule

// File: rtl/pkt_xbar_router.sv
module pkt_xbar_router #(
  parameter int NUM_PORTS = 4,
  parameter int CHAR_W    = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_PORTS-1:0]        in_valid_i,
  input  logic [NUM_PORTS-1:0]        in_ctrl_i,
  input  logic [NUM_PORTS*CHAR_W-1:0] in_data_i,
  output logic [NUM_PORTS-1:0]        in_ready_o,
  output logic [NUM_PORTS-1:0]        out_valid_o,
  output logic [NUM_PORTS-1:0]        out_ctrl_o,
  output logic [NUM_PORTS*CHAR_W-1:0] out_data_o,
  input  logic [NUM_PORTS-1:0]        out_ready_i
);
  localparam int AW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  logic [NUM_PORTS-1:0]           req_w, rel_w, gnt_in_w, busy_w, fwd_ready_w;
  logic [NUM_PORTS*AW-1:0]        dest_w, owner_w;
  logic [2*NUM_PORTS-1:0]         st_w;
  logic [NUM_PORTS*NUM_PORTS-1:0] gnt_m;  // [j*N+i]: egress j grants ingress i

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_in
    pkt_xbar_ingress #(.NUM_PORTS(NUM_PORTS), .CHAR_W(CHAR_W), .AW(AW)) u_ing (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .valid_i    (in_valid_i[i]),
      .ctrl_i     (in_ctrl_i[i]),
      .data_i     (in_data_i[i*CHAR_W +: CHAR_W]),
      .fwd_ready_i(fwd_ready_w[i]),
      .grant_i    (gnt_in_w[i]),
      .ready_o    (in_ready_o[i]),
      .req_o      (req_w[i]),
      .dest_o     (dest_w[i*AW +: AW]),
      .state_o    (st_w[2*i +: 2]),
      .release_o  (rel_w[i])
    );
  end

  for (genvar j = 0; j < NUM_PORTS; j++) begin : g_out
    logic [NUM_PORTS-1:0] req_j;
    always_comb begin
      for (int i = 0; i < NUM_PORTS; i++)
        req_j[i] = req_w[i] && (dest_w[i*AW +: AW] == AW'(j));
    end
    pkt_xbar_arb #(.NUM_PORTS(NUM_PORTS), .AW(AW)) u_arb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (req_j),
      .rel_i  (rel_w),
      .busy_o (busy_w[j]),
      .owner_o(owner_w[j*AW +: AW]),
      .gnt_o  (gnt_m[j*NUM_PORTS +: NUM_PORTS])
    );
  end

  always_comb begin
    gnt_in_w = '0;
    for (int j = 0; j < NUM_PORTS; j++)
      gnt_in_w = gnt_in_w | gnt_m[j*NUM_PORTS +: NUM_PORTS];
  end

  pkt_xbar_fabric #(.NUM_PORTS(NUM_PORTS), .CHAR_W(CHAR_W), .AW(AW)) u_fabric (
    .in_valid_i (in_valid_i),
    .in_ctrl_i  (in_ctrl_i),
    .in_data_i  (in_data_i),
    .dest_i     (dest_w),
    .busy_i     (busy_w),
    .owner_i    (owner_w),
    .out_ready_i(out_ready_i),
    .out_valid_o(out_valid_o),
    .out_ctrl_o (out_ctrl_o),
    .out_data_o (out_data_o),
    .fwd_ready_o(fwd_ready_w)
  );
endmodule

// File: rtl/pkt_xbar_chk.sv
module pkt_xbar_chk
  import pkt_xbar_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int CHAR_W    = 8,
  parameter int AW        = 2
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [NUM_PORTS-1:0]        in_ready_i,
  input logic [NUM_PORTS-1:0]        out_valid_i,
  input logic [NUM_PORTS-1:0]        out_ctrl_i,
  input logic [NUM_PORTS*CHAR_W-1:0] out_data_i,
  input logic [NUM_PORTS-1:0]        out_ready_i,
  input logic [2*NUM_PORTS-1:0]      st_i,
  input logic [NUM_PORTS*AW-1:0]     dest_i,
  input logic [NUM_PORTS-1:0]        busy_i
);
  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_i
    a_r6_waiter_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ing_state_e'(st_i[2*i +: 2]) == ST_REQ |-> !in_ready_i[i]);
    a_r8_drop_consumes: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ing_state_e'(st_i[2*i +: 2]) == ST_DROP |-> in_ready_i[i]);
  end

  for (genvar j = 0; j < NUM_PORTS; j++) begin : g_j
    logic [NUM_PORTS-1:0] conn;
    always_comb begin
      for (int i = 0; i < NUM_PORTS; i++)
        conn[i] = (ing_state_e'(st_i[2*i +: 2]) == ST_FWD) && (dest_i[i*AW +: AW] == AW'(j));
    end
    a_r10_one_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(conn));
    a_r7_hold_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_i[j] && !out_ready_i[j] |=> out_valid_i[j] && $stable(out_data_i[j*CHAR_W +: CHAR_W]));
    a_r4_marker_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_i[j] && out_ready_i[j] && out_ctrl_i[j] |=> !busy_i[j]);
  end
endmodule

bind pkt_xbar_router pkt_xbar_chk #(.NUM_PORTS(NUM_PORTS), .CHAR_W(CHAR_W), .AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_ready_i (in_ready_o),
  .out_valid_i(out_valid_o),
  .out_ctrl_i (out_ctrl_o),
  .out_data_i (out_data_o),
  .out_ready_i(out_ready_i),
  .st_i       (st_w),
  .dest_i     (dest_w),
  .busy_i     (busy_w)
);

// File: tb/pkt_xbar_router_tb.sv
`timescale 1ns/1ps
module pkt_xbar_router_tb;
  localparam int NP = 4;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          iv [NP];
  logic          ic [NP];
  logic [CW-1:0] id [NP];
  logic          ordy [NP];

  logic [NP-1:0]    in_valid, in_ctrl, in_ready, out_valid, out_ctrl, out_ready;
  logic [NP*CW-1:0] in_data, out_data;

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      in_valid[p]         = iv[p];
      in_ctrl[p]          = ic[p];
      in_data[p*CW +: CW] = id[p];
      out_ready[p]        = ordy[p];
    end
  end

  pkt_xbar_router #(.NUM_PORTS(NP), .CHAR_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ctrl_i(in_ctrl), .in_data_i(in_data), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_ctrl_o(out_ctrl), .out_data_o(out_data), .out_ready_i(out_ready)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [CW:0] got_q [NP][$];  // {ctrl, data}

  // capture egress transfers just before the rising edge
  initial begin
    forever begin
      @(negedge clk); #5;
      for (int j = 0; j < NP; j++)
        if (rst_n && out_valid[j] && out_ready[j]) got_q[j].push_back({out_ctrl[j], out_data[j*CW +: CW]});
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put_char(input int p, input logic c, input logic [CW-1:0] d);
    bit acc = 0;
    @(negedge clk);
    iv[p] = 1'b1; ic[p] = c; id[p] = d;
    while (!acc) begin
      #5; acc = in_ready[p];
      @(posedge clk);
      if (!acc) @(negedge clk);
    end
  endtask

  task automatic send_pkt(input int p, input int hdr, input int n, input logic [CW-1:0] base, input logic eom);
    put_char(p, 1'b0, CW'(hdr));
    for (int k = 0; k < n; k++) put_char(p, 1'b0, base + CW'(k));
    put_char(p, 1'b1, {{(CW-1){1'b0}}, eom});
    @(negedge clk); iv[p] = 1'b0;
  endtask

  task automatic expect_pkt(input int j, input int n, input logic [CW-1:0] base, input logic eom, input string req);
    for (int k = 0; k < n; k++) begin
      logic [CW:0] e = {1'b0, base + CW'(k)};
      if (got_q[j].size() == 0) begin check(0, req, -1, int'(e)); return; end
      begin
        logic [CW:0] g = got_q[j].pop_front();
        check(g == e, req, int'(g), int'(e));
      end
    end
    if (got_q[j].size() == 0) begin check(0, req, -1, 256 + int'(eom)); return; end
    begin
      logic [CW:0] g = got_q[j].pop_front();
      check(g == {1'b1, {(CW-1){1'b0}}, eom}, req, int'(g), 256 + int'(eom));
    end
  endtask

  task automatic expect_empty(input string req);
    for (int j = 0; j < NP; j++) check(got_q[j].size() == 0, req, got_q[j].size(), 0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk); #5;
    check(out_valid == '0, "R1 out_valid", int'(out_valid), 0);
    check(in_ready == '1, "R1 in_ready", int'(in_ready), 15);
  endtask

  task automatic t_basic;
    send_pkt(0, 2, 3, 8'h10, 1'b0);
    idle(3);
    check(got_q[2].size() == 4, "R2 header stripped, count", got_q[2].size(), 4);
    expect_pkt(2, 3, 8'h10, 1'b0, "R3 payload order R4 EOP last");
    expect_empty("R2 no other egress");
  endtask

  task automatic t_eom_reuse;
    send_pkt(1, 3, 2, 8'h40, 1'b1);
    send_pkt(2, 3, 2, 8'h50, 1'b0);
    idle(3);
    expect_pkt(3, 2, 8'h40, 1'b1, "R4 EOM closes");
    expect_pkt(3, 2, 8'h50, 1'b0, "R4 egress reusable");
    expect_empty("R4 residue");
  endtask

  task automatic t_contention;
    fork
      send_pkt(0, 1, 3, 8'h20, 1'b0);
      send_pkt(2, 1, 3, 8'h30, 1'b0);
      begin
        idle(3); #5;
        check(in_ready[2] == 1'b0, "R6 loser stalled", int'(in_ready[2]), 0);
      end
    join
    idle(3);
    expect_pkt(1, 3, 8'h20, 1'b0, "R5 port0 wins first R10");
    expect_pkt(1, 3, 8'h30, 1'b0, "R6 loser follows intact");
    fork
      send_pkt(1, 1, 2, 8'h60, 1'b1);
      send_pkt(3, 1, 2, 8'h70, 1'b0);
    join
    idle(3);
    expect_pkt(1, 2, 8'h70, 1'b0, "R5 rotated to port3");
    expect_pkt(1, 2, 8'h60, 1'b1, "R5 port1 second");
    expect_empty("R10 no leakage");
  endtask

  task automatic t_backpressure;
    @(negedge clk); ordy[0] = 1'b0;
    fork
      send_pkt(3, 0, 2, 8'h80, 1'b0);
      begin
        idle(6); #5;
        check(in_ready[3] == 1'b0, "R7 ingress stalled", int'(in_ready[3]), 0);
        check(out_valid[0] == 1'b1, "R7 egress valid held", int'(out_valid[0]), 1);
        check(out_data[7:0] == 8'h80, "R7 egress data held", int'(out_data[7:0]), 128);
        check(got_q[0].size() == 0, "R7 nothing taken", got_q[0].size(), 0);
        @(negedge clk); ordy[0] = 1'b1;
      end
    join
    idle(3);
    expect_pkt(0, 2, 8'h80, 1'b0, "R7 no loss");
    expect_empty("R7 residue");
  endtask

  task automatic t_bad_header;
    send_pkt(1, 7, 3, 8'h90, 1'b0);
    idle(3);
    expect_empty("R8 discarded");
    #5 check(in_ready[1] == 1'b1, "R8 ingress idle again", int'(in_ready[1]), 1);
    send_pkt(1, 0, 1, 8'hA0, 1'b1);
    idle(3);
    expect_pkt(0, 1, 8'hA0, 1'b1, "R8 following packet routed");
  endtask

  task automatic t_parallel;
    fork
      send_pkt(0, 1, 4, 8'hB0, 1'b0);
      send_pkt(1, 0, 4, 8'hC0, 1'b1);
      send_pkt(2, 3, 4, 8'hD0, 1'b0);
    join
    idle(3);
    expect_pkt(1, 4, 8'hB0, 1'b0, "R9 path 0->1");
    expect_pkt(0, 4, 8'hC0, 1'b1, "R9 path 1->0");
    expect_pkt(3, 4, 8'hD0, 1'b0, "R9 path 2->3");
    expect_empty("R9 residue");
  endtask

  task automatic t_stray_marker;
    put_char(2, 1'b1, 8'h00);
    @(negedge clk); iv[2] = 1'b0;
    idle(3);
    expect_empty("R11 stray marker ignored");
    send_pkt(2, 2, 1, 8'hE0, 1'b0);
    idle(3);
    expect_pkt(2, 1, 8'hE0, 1'b0, "R11 next packet normal");
  endtask

  initial begin
    for (int p = 0; p < NP; p++) begin iv[p] = 0; ic[p] = 0; id[p] = '0; ordy[p] = 1; end
    idle(3);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_eom_reuse();
    t_contention();
    t_backpressure();
    t_bad_header();
    t_parallel();
    t_stray_marker();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #4ms;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule